// File: doc/BRIEF.md
# Outer-Product Update Sequencer

This block takes the 64-bit operand word of a fused multiply-subtract instruction on 64-bit elements. It expands the word into the series of element updates that the instruction implies. A one-cycle start pulse latches the word. The block then hands out one update command per cycle over a valid/ready link to a floating-point unit outside the block. Each command names the X lane and Y lane to read, the Z row and Z lane to write, and a 3-bit selector that tells the unit which simplified form of z − x·y to compute.

There are two modes. In pointwise (vector) mode, every enabled lane i pairs X lane i with Y lane i and writes row `zRow`, lane i. In outer-product (matrix) mode, every enabled X lane i is combined with every enabled Y lane j. Each such pair writes row j·8 + (zRow mod 8), lane i. Two lane masks restrict the updates, one for X and one for Y. Each mask is decoded from a 2-bit mode and a 5-bit value. The sequencer spends no cycle on a pair that a mask disables. A done pulse closes each instruction.

Top module: `opUpdateSeq`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done` and `cmdValid` are low until a start is taken.
- R2: A `start` seen while idle latches `operand`. `busy` is high from the next cycle, and later changes of `operand` have no effect. A `start` seen while busy or during the done cycle is ignored.
- R3: Each lane mask is decoded from a mode and a value N, with lanes numbered 0..7:
  - Mode 0: all lanes if N=0, odd lanes if N=1, even lanes if N=2, and no lanes otherwise.
  - Mode 1: only lane N.
  - Mode 2: lanes below N, or all lanes if N=0.
  - Mode 3: the top N lanes, or all lanes if N=0.
- R4: Vector mode (operand bit 63 = 1): each enabled X lane i yields one command with X lane i, Y lane i, Z lane i and Z row equal to operand bits 25:20. The Y mask fields are ignored.
- R5: Matrix mode (bit 63 = 0): each enabled X lane i and enabled Y lane j yields one command with X lane i, Y lane j, Z lane i and Z row j·8 + bits 22:20. Bits 25:23 are ignored.
- R6: `cmdOp` equals operand bits 29:27. Bit 29 drops X, bit 28 drops Y and bit 27 drops Z. Codes 0..7 mean z−x·y, −x·y, z−x, −x, z−y, −y, z and −0.
- R7: Commands come in order with X lane as the outer loop and Y lane as the inner loop. With `cmdReady` held high, one command is accepted in every cycle, with no idle cycles for disabled pairs.
- R8: While `cmdValid` is high and `cmdReady` is low, `cmdValid` and all command fields hold their values in the next cycle.
- R9: `done` is high for exactly one cycle, the cycle after the last command is accepted. `busy` is low in that cycle. With no enabled pair, `done` comes two cycles after the start edge.
- R10: Operand fields:
  - X mask: mode in bits 47:46, value in bits 45:41.
  - Y mask: mode in bits 38:37, value in bits 36:32.
  - Z row: bits 25:20.
  - Operation selector: bits 29:27.
  - Mode select: bit 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a new instruction when idle |
| operand | input | 64 | Instruction operand word, sampled with start |
| cmdReady | input | 1 | Floating-point unit accepts the current command |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle pulse after the last update |
| cmdValid | output | 1 | Command fields are valid |
| cmdXLane | output | 3 | X lane to read |
| cmdYLane | output | 3 | Y lane to read |
| cmdZRow | output | 6 | Z row to update |
| cmdZLane | output | 3 | Z lane to update |
| cmdOp | output | 3 | Operation selector |

## Verification
The start edge sets `busy`, and the first command is visible in the same cycle that `busy` first reads high. A command is accepted at the rising edge where `cmdValid` and `cmdReady` are both high, and the next command is visible right after that edge. `done` appears in the cycle after the last acceptance, or two cycles after the start edge when no pair is enabled. The bench drives inputs and reads outputs on the falling edge. It compares each accepted command with the next entry of a reference list built from the loop model. With ready held high, it also checks that `done` arrives exactly at sample max(n,1)+1 after the start edge.

// File: rtl/opUpdateSeqPkg.sv
package opUpdateSeqPkg;
  // operand field positions
  localparam int VEC_BIT   = 63;
  localparam int X_MODE_LO = 46;
  localparam int X_VAL_LO  = 41;
  localparam int Y_MODE_LO = 37;
  localparam int Y_VAL_LO  = 32;
  localparam int SKIP_LO   = 27;
  localparam int ZROW_LO   = 20;
  localparam int MODE_W    = 2;
  localparam int VAL_W     = 5;
  localparam int OP_W      = 3;

  typedef struct packed {
    logic load;     // capture operand, build pair set
    logic advance;  // retire current pair
  } seqStrobes_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} seqState_t;
endpackage

// File: rtl/laneMaskDecode.sv
module laneMaskDecode #(
  parameter int LANES = 8,
  parameter int VAL_W = 5
) (
  input  logic [1:0]       mode,
  input  logic [VAL_W-1:0] value,
  output logic [LANES-1:0] mask
);
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      unique case (mode)
        2'd0: mask[k] = (value == '0) ||
                        (value == VAL_W'(1) && (k % 2 == 1)) ||
                        (value == VAL_W'(2) && (k % 2 == 0));
        2'd1: mask[k] = (int'(value) == k);
        2'd2: mask[k] = (value == '0) || (k < int'(value));
        default: mask[k] = (value == '0) || (k >= LANES - int'(value));
      endcase
    end
  end
endmodule

// File: rtl/opUpdateDatapath.sv
module opUpdateDatapath
  import opUpdateSeqPkg::*;
#(
  parameter int LANES  = 8,
  parameter int ZROW_W = 6,
  localparam int LANE_W = $clog2(LANES),
  localparam int PAIRS  = LANES * LANES,
  localparam int PAIR_W = $clog2(PAIRS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [63:0]       operand,
  output logic              pending,
  output logic              lastOne,
  output logic [LANE_W-1:0] cmdXLane,
  output logic [LANE_W-1:0] cmdYLane,
  output logic [ZROW_W-1:0] cmdZRow,
  output logic [LANE_W-1:0] cmdZLane,
  output logic [OP_W-1:0]   cmdOp
);
  logic [LANES-1:0]  xMask, yMask;
  logic [PAIRS-1:0]  pairEn;
  logic [PAIRS-1:0]  remQ;
  logic              vecQ;
  logic [ZROW_W-1:0] zRowQ;
  logic [OP_W-1:0]   opQ;
  logic [PAIR_W-1:0] curIdx;
  logic [LANE_W-1:0] xIdx, yIdx;

  laneMaskDecode #(.LANES(LANES), .VAL_W(VAL_W)) u_xMask (
    .mode (operand[X_MODE_LO +: MODE_W]),
    .value(operand[X_VAL_LO +: VAL_W]),
    .mask (xMask)
  );

  laneMaskDecode #(.LANES(LANES), .VAL_W(VAL_W)) u_yMask (
    .mode (operand[Y_MODE_LO +: MODE_W]),
    .value(operand[Y_VAL_LO +: VAL_W]),
    .mask (yMask)
  );

  // pair index = xLane*LANES + yLane; vector mode uses only yLane==0 slots
  for (genvar gi = 0; gi < LANES; gi++) begin : g_x
    for (genvar gj = 0; gj < LANES; gj++) begin : g_y
      localparam bit FIRST_COL = (gj == 0);
      assign pairEn[gi*LANES + gj] =
        xMask[gi] & (operand[VEC_BIT] ? FIRST_COL : yMask[gj]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remQ  <= '0;
      vecQ  <= 1'b0;
      zRowQ <= '0;
      opQ   <= '0;
    end else if (strobes.load) begin
      remQ  <= pairEn;
      vecQ  <= operand[VEC_BIT];
      zRowQ <= operand[ZROW_LO +: ZROW_W];
      opQ   <= operand[SKIP_LO +: OP_W];
    end else if (strobes.advance) begin
      remQ  <= remQ & (remQ - PAIRS'(1));
    end
  end

  always_comb begin
    curIdx = '0;
    for (int p = PAIRS - 1; p >= 0; p--) begin
      if (remQ[p]) curIdx = PAIR_W'(p);
    end
  end

  assign pending = |remQ;
  assign lastOne = pending && ((remQ & (remQ - PAIRS'(1))) == '0);

  assign xIdx     = curIdx[PAIR_W-1:LANE_W];
  assign yIdx     = curIdx[LANE_W-1:0];
  assign cmdXLane = xIdx;
  assign cmdZLane = xIdx;
  assign cmdYLane = vecQ ? xIdx : yIdx;
  assign cmdZRow  = vecQ ? zRowQ
                         : ((ZROW_W'(yIdx) << LANE_W) | ZROW_W'(zRowQ[LANE_W-1:0]));
  assign cmdOp    = opQ;
endmodule

// File: rtl/opUpdateControl.sv
module opUpdateControl
  import opUpdateSeqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        cmdReady,
  input  logic        pending,
  input  logic        lastOne,
  output seqStrobes_t strobes,
  output logic        busy,
  output logic        done,
  output logic        cmdValid
);
  seqState_t stateQ, stateD;
  logic      fire;

  assign cmdValid = (stateQ == ST_RUN) && pending;
  assign fire     = cmdValid && cmdReady;
  assign busy     = (stateQ == ST_RUN);
  assign done     = (stateQ == ST_FIN);

  always_comb begin
    stateD          = stateQ;
    strobes.load    = 1'b0;
    strobes.advance = fire;
    unique case (stateQ)
      ST_IDLE: if (start) begin
        strobes.load = 1'b1;
        stateD       = ST_RUN;
      end
      ST_RUN: if (!pending || (fire && lastOne)) stateD = ST_FIN;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end
endmodule

// File: rtl/opUpdateSeq.sv
module opUpdateSeq
  import opUpdateSeqPkg::*;
#(
  parameter int LANES  = 8,
  parameter int ZROW_W = 6,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [63:0]       operand,
  input  logic              cmdReady,
  output logic              busy,
  output logic              done,
  output logic              cmdValid,
  output logic [LANE_W-1:0] cmdXLane,
  output logic [LANE_W-1:0] cmdYLane,
  output logic [ZROW_W-1:0] cmdZRow,
  output logic [LANE_W-1:0] cmdZLane,
  output logic [OP_W-1:0]   cmdOp
);
  seqStrobes_t strobes;
  logic        pending, lastOne;

  opUpdateControl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cmdReady(cmdReady),
    .pending(pending), .lastOne(lastOne), .strobes(strobes),
    .busy(busy), .done(done), .cmdValid(cmdValid)
  );

  opUpdateDatapath #(.LANES(LANES), .ZROW_W(ZROW_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .operand(operand),
    .pending(pending), .lastOne(lastOne),
    .cmdXLane(cmdXLane), .cmdYLane(cmdYLane), .cmdZRow(cmdZRow),
    .cmdZLane(cmdZLane), .cmdOp(cmdOp)
  );
endmodule

// File: rtl/opUpdateSeqChecker.sv
module opUpdateSeqChecker #(
  parameter int LANE_W = 3,
  parameter int ZROW_W = 6,
  parameter int OP_W   = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdReady,
  input logic              busy,
  input logic              done,
  input logic              cmdValid,
  input logic [LANE_W-1:0] cmdXLane,
  input logic [LANE_W-1:0] cmdYLane,
  input logic [ZROW_W-1:0] cmdZRow,
  input logic [LANE_W-1:0] cmdZLane,
  input logic [OP_W-1:0]   cmdOp
);
  a_r1_valid_needs_busy: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> busy);

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdXLane) && $stable(cmdYLane)
      && $stable(cmdZRow) && $stable(cmdZLane) && $stable(cmdOp)));

  // R4 R5: Z lane always follows the X lane
  a_r5_zlane_follows_x: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdZLane == cmdXLane));

  a_r7_order_rises: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> (!cmdValid ||
      ({cmdXLane, cmdYLane} > $past({cmdXLane, cmdYLane}))));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy));
endmodule

bind opUpdateSeq opUpdateSeqChecker i_chk (
  .clk(clk), .rstN(rstN), .cmdReady(cmdReady), .busy(busy), .done(done),
  .cmdValid(cmdValid), .cmdXLane(cmdXLane), .cmdYLane(cmdYLane),
  .cmdZRow(cmdZRow), .cmdZLane(cmdZLane), .cmdOp(cmdOp)
);

// File: tb/test_opUpdateSeq.sv
`timescale 1ns/1ps
module test_opUpdateSeq;
  logic        clk = 1'b0, rstN = 1'b0, start = 1'b0, cmdReady = 1'b0;
  logic [63:0] operand = '0;
  logic        busy, done, cmdValid;
  logic [2:0]  cmdXLane, cmdYLane, cmdZLane, cmdOp;
  logic [5:0]  cmdZRow;

  int nChecks = 0, nFails = 0;
  logic [17:0] expCmd [64];
  int          expN;

  always #2.5 clk = ~clk;

  opUpdateSeq i_opUpdateSeq (
    .clk(clk), .rstN(rstN), .start(start), .operand(operand), .cmdReady(cmdReady),
    .busy(busy), .done(done), .cmdValid(cmdValid), .cmdXLane(cmdXLane),
    .cmdYLane(cmdYLane), .cmdZRow(cmdZRow), .cmdZLane(cmdZLane), .cmdOp(cmdOp)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R3 lane mask model
  function automatic logic [7:0] refMask(input logic [1:0] mode, input logic [4:0] n);
    logic [7:0] m;
    for (int k = 0; k < 8; k++) begin
      case (mode)
        2'd0: m[k] = (n == 0) || (n == 1 && k % 2 == 1) || (n == 2 && k % 2 == 0);
        2'd1: m[k] = (int'(n) == k);
        2'd2: m[k] = (n == 0) || (k < int'(n));
        default: m[k] = (n == 0) || (k + int'(n) >= 8);
      endcase
    end
    return m;
  endfunction

  // R4 R5 R6 R10 reference loop
  function automatic void buildRef(input logic [63:0] op);
    logic [7:0] xm, ym;
    xm = refMask(op[47:46], op[45:41]);
    ym = refMask(op[38:37], op[36:32]);
    expN = 0;
    for (int i = 0; i < 8; i++) begin
      if (!xm[i]) continue;
      if (op[63]) begin
        expCmd[expN] = {3'(i), 3'(i), op[25:20], 3'(i), op[29:27]};
        expN++;
      end else begin
        for (int j = 0; j < 8; j++) begin
          if (!ym[j]) continue;
          expCmd[expN] = {3'(i), 3'(j), 6'(j * 8 + int'(op[22:20])), 3'(i), op[29:27]};
          expN++;
        end
      end
    end
  endfunction

  function automatic logic [63:0] mkOp(input bit vec, input logic [1:0] xm, input logic [4:0] xv,
                                       input logic [1:0] ym, input logic [4:0] yv,
                                       input logic [2:0] skip, input logic [5:0] zr);
    logic [63:0] o;
    o = '0;
    o[63] = vec; o[47:46] = xm; o[45:41] = xv; o[38:37] = ym; o[36:32] = yv;
    o[29:27] = skip; o[25:20] = zr;
    o[18:10] = 9'h1a5; o[8:0] = 9'h0c3;
    return o;
  endfunction

  task automatic runOp(input logic [63:0] op, input bit randReady, input bit junkStart);
    int k = 0, samples = 0;
    bit held = 0, finished = 0, r;
    logic [17:0] act, last;
    buildRef(op);
    @(negedge clk);
    operand = op; start = 1'b1; cmdReady = 1'b1;
    @(negedge clk);
    while (!finished && samples < 300) begin
      samples++;
      act = {cmdXLane, cmdYLane, cmdZRow, cmdZLane, cmdOp};
      if (samples == 1) check(busy == 1'b1, "R2", "busy after start", 64'(busy), 1);
      if (held) check(cmdValid && act == last, "R8", "held command", 64'(act), 64'(last));
      if (cmdValid && k >= expN) check(0, "R7", "extra command", 64'(k), 64'(expN));
      if (done) begin
        check(k == expN, "R9", "commands before done", 64'(k), 64'(expN));
        check(busy == 1'b0, "R9", "busy in done cycle", 64'(busy), 0);
        if (!randReady)
          check(samples == ((expN == 0) ? 2 : expN + 1), "R7 R9", "done timing",
                64'(samples), 64'((expN == 0) ? 2 : expN + 1));
        finished = 1;
      end
      r = randReady ? 1'($urandom % 2) : 1'b1;
      if (cmdValid && r && k < expN) begin
        check(act[17:3] == expCmd[k][17:3], op[63] ? "R3 R4 R7 R10" : "R3 R5 R7 R10",
              "command fields", 64'(act), 64'(expCmd[k]));
        check(act[2:0] == expCmd[k][2:0], "R6", "op selector", 64'(act[2:0]), 64'(expCmd[k][2:0]));
        k++;
      end
      held = cmdValid && !r;
      last = act;
      cmdReady = r;
      start = (junkStart && samples == 2) ? 1'b1 : 1'b0;
      operand = (junkStart && samples == 2) ? 64'h0 : ~op;
      @(negedge clk);
    end
    start = 1'b0; cmdReady = 1'b0;
    if (!finished) check(0, "R9", "done never seen", 0, 1);
    check(!busy && !done && !cmdValid, "R2", "idle after done",
          64'({busy, done, cmdValid}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    logic [63:0] op;
    int unsigned seedDummy;
    seedDummy = $urandom(32'd4177);
    repeat (3) @(negedge clk);
    check(!busy && !done && !cmdValid, "R1", "in reset", 64'({busy, done, cmdValid}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !cmdValid, "R1", "after reset", 64'({busy, done, cmdValid}), 0);

    runOp(mkOp(1, 2'd0, 5'd0, 2'd0, 5'd7, 3'd2, 6'd45), 0, 0);   // R4 vector, Y fields ignored
    runOp(mkOp(0, 2'd0, 5'd0, 2'd0, 5'd0, 3'd0, 6'd63), 0, 0);   // R5 full 64, high row bits
    runOp(mkOp(0, 2'd0, 5'd3, 2'd0, 5'd0, 3'd7, 6'd5), 0, 0);    // R9 empty
    runOp(mkOp(0, 2'd1, 5'd5, 2'd3, 5'd2, 3'd5, 6'd12), 0, 0);   // R3 single lane, last N
    runOp(mkOp(0, 2'd2, 5'd3, 2'd0, 5'd1, 3'd1, 6'd9), 0, 0);    // R3 first N, odd lanes
    runOp(mkOp(1, 2'd1, 5'd9, 2'd0, 5'd0, 3'd4, 6'd1), 0, 0);    // R3 lane out of range
    runOp(mkOp(1, 2'd0, 5'd2, 2'd1, 5'd3, 3'd6, 6'd33), 1, 0);   // R3 even lanes, vector
    runOp(mkOp(0, 2'd2, 5'd2, 2'd0, 5'd1, 3'd3, 6'd17), 0, 1);   // R2 start while busy
    runOp(mkOp(0, 2'd0, 5'd3, 2'd0, 5'd0, 3'd0, 6'd0), 0, 1);    // R2 start in done cycle
    runOp(mkOp(0, 2'd3, 5'd0, 2'd2, 5'd12, 3'd0, 6'd2), 1, 0);   // R8 random ready

    for (int t = 0; t < 60; t++) begin
      op = {$urandom, $urandom};
      if ($urandom % 2) op[45:41] = 5'($urandom % 10);
      if ($urandom % 2) op[36:32] = 5'($urandom % 10);
      runOp(op, 1'($urandom % 2), 1'($urandom % 4 == 0));
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule